// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Register

This block holds the accumulator, the X index register and the eight-bit processor status word of a small 8-bit processor core, and applies one arithmetic or logic operation to them per clock. A surrounding sequencer presents an operation code and an 8-bit operand together with a valid strobe. On the next rising clock edge the accumulator or X takes its new value and the status flags follow from that same result. Cycles without the strobe leave every register as it was.

Arithmetic is always binary. Add and subtract share a single carry-chain adder, and subtraction feeds it the inverted operand. Signed overflow is judged from the signs of the two adder inputs and of the result. Instruction fetch, decoding, addressing, memory, the stack and interrupts belong to other blocks.

Top module: `accu_core`

## Requirements
- R1: A synchronous reset sets status to 0x24, meaning only bit 2 (interrupt disable) and bit 5 are 1. It clears the accumulator and X to 0x00. Reset takes priority over a valid operation presented in the same cycle.
- R2: When `op_valid` is low, or when `op_code` is 6 or 7, the accumulator, X and status all keep their values.
- R3: Add (op_code 0) forms the 9-bit sum of the accumulator, the operand and status bit 0 (carry). The accumulator keeps the low 8 bits. Carry becomes 1 exactly when the sum exceeds 0xFF.
- R4: After an add or subtract, status bit 6 (overflow) equals bit 7 of ((adder operand XOR result) AND (result XOR previous accumulator)).
- R5: Subtract (op_code 1) behaves as an add of the bitwise complement of the operand. Carry 1 afterwards means no borrow occurred.
- R6: Every value written to the accumulator or to X sets status bit 1 (zero) when that value is 0x00, and clears it otherwise. Status bit 7 (negative) takes bit 7 of that value.
- R7: AND (op_code 2) writes the accumulator ANDed with the operand into the accumulator. Load (op_code 3) writes the operand into the accumulator. Neither operation changes carry or overflow.
- R8: Increment X (op_code 5) adds one to X and wraps from 0xFF to 0x00. It leaves carry and overflow unchanged.
- R9: Transfer (op_code 4) copies the accumulator into X and leaves the accumulator unchanged.
- R10: Status bits 2 to 5 keep their reset value 4'b1001 through every operation. The decimal bit never alters the arithmetic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Apply `op_code` at the next edge |
| op_code | input | 3 | 0 add, 1 subtract, 2 AND, 3 load, 4 A-to-X, 5 increment X |
| operand | input | 8 | Data operand for add, subtract, AND and load |
| acc_q | output | 8 | Accumulator |
| x_q | output | 8 | X index register |
| status_q | output | 8 | Status: 0 C, 1 Z, 2 I, 3 D, 4 B, 5 fixed one, 6 V, 7 N |

## Verification
Two things can land on the same edge. The first is a valid add together with reset. The bench raises both in one cycle and expects the reset values, not the sum. The second is a register write together with its zero and negative update. Every operation is checked on its data register and on its full status word in the same sampled cycle. The cases include a carry that produces a zero result, a subtraction that borrows and a wrap of X, so a flag that lags by one edge, or one taken from the old value, shows up as a mismatch.

// File: rtl/accu_pkg.sv
package accu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_ADC  = 3'd0,
        OP_SBC  = 3'd1,
        OP_AND  = 3'd2,
        OP_LOAD = 3'd3,
        OP_XFER = 3'd4,
        OP_INCX = 3'd5
    } op_e;

    // status bit positions
    localparam int ST_C = 0;
    localparam int ST_Z = 1;
    localparam int ST_I = 2;
    localparam int ST_D = 3;
    localparam int ST_B = 4;
    localparam int ST_U = 5;
    localparam int ST_V = 6;
    localparam int ST_N = 7;

    localparam logic [7:0] STATUS_RST = 8'h24;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] x;
        logic [7:0]        p;
    } arch_t;

    function automatic logic [7:0] set_zn(input logic [7:0] p,
                                          input logic [DATA_W-1:0] v);
        logic [7:0] r;
        r       = p;
        r[ST_Z] = (v == '0);
        r[ST_N] = v[DATA_W-1];
        return r;
    endfunction

endpackage

// File: rtl/accu_adder.sv
module accu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         cin,
    input  logic         invert,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] rhs_eff;
    logic [W-1:0] sign_mix;

    always_comb begin
        rhs_eff     = invert ? ~rhs : rhs;
        {cout, sum} = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, cin};
        sign_mix    = (rhs_eff ^ sum) & (sum ^ lhs);
        ovf         = sign_mix[W-1];
    end
endmodule

// File: rtl/accu_next.sv
module accu_next
    import accu_pkg::*;
(
    input  arch_t             cur,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] add_sum,
    input  logic              add_cout,
    input  logic              add_ovf,
    output arch_t             nxt
);
    logic              wr;
    logic [DATA_W-1:0] wval;

    always_comb begin
        nxt  = cur;
        wr   = 1'b0;
        wval = '0;
        case (op_code)
            OP_ADC, OP_SBC: begin
                nxt.a       = add_sum;
                nxt.p[ST_C] = add_cout;
                nxt.p[ST_V] = add_ovf;
                wval        = add_sum;
                wr          = 1'b1;
            end
            OP_AND: begin
                nxt.a = cur.a & operand;
                wval  = cur.a & operand;
                wr    = 1'b1;
            end
            OP_LOAD: begin
                nxt.a = operand;
                wval  = operand;
                wr    = 1'b1;
            end
            OP_XFER: begin
                nxt.x = cur.a;
                wval  = cur.a;
                wr    = 1'b1;
            end
            OP_INCX: begin
                nxt.x = cur.x + 1'b1;
                wval  = cur.x + 1'b1;
                wr    = 1'b1;
            end
            default: ;
        endcase
        if (wr) nxt.p = set_zn(nxt.p, wval);
    end
endmodule

// File: rtl/accu_core.sv
module accu_core
    import accu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [2:0]  op_code,
    input  logic [7:0]  operand,
    output logic [7:0]  acc_q,
    output logic [7:0]  x_q,
    output logic [7:0]  status_q
);
    arch_t             st;
    arch_t             st_nxt;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              add_ovf;

    accu_adder #(.W(DATA_W)) u_add (
        .lhs    (st.a),
        .rhs    (operand),
        .cin    (st.p[ST_C]),
        .invert (op_code == OP_SBC),
        .sum    (add_sum),
        .cout   (add_cout),
        .ovf    (add_ovf)
    );

    accu_next u_next (
        .cur      (st),
        .op_code  (op_code),
        .operand  (operand),
        .add_sum  (add_sum),
        .add_cout (add_cout),
        .add_ovf  (add_ovf),
        .nxt      (st_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st.a <= '0;
            st.x <= '0;
            st.p <= STATUS_RST;
        end else if (op_valid) begin
            st <= st_nxt;
        end
    end

    assign acc_q    = st.a;
    assign x_q      = st.x;
    assign status_q = st.p;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (status_q == 8'h24 && acc_q == 8'h00 && x_q == 8'h00));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_code > 3'd5) |=>
            ($stable(acc_q) && $stable(x_q) && $stable(status_q)));

    // R3
    adc_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd0) |=>
            ({status_q[0], acc_q} == (9'($past(acc_q)) + 9'($past(operand))
                                      + 9'($past(status_q[0])))));

    // R8
    incx_cv_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd5) |=>
            ($stable(status_q[0]) && $stable(status_q[6])));

    // R9
    xfer_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd4) |=>
            (x_q == $past(acc_q) && status_q[1] == (x_q == 8'h00)
             && status_q[7] == x_q[7]));

    // R10
    ctrl_bits_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> $stable(status_q[5:2]));
endmodule

// File: tb/sim_accu_core.sv
`timescale 1ns/1ps
module sim_accu_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc_q;
    logic [7:0] x_q;
    logic [7:0] status_q;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mA, mX, mP;

    always #2.5 clk = ~clk;

    accu_core u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .acc_q(acc_q), .x_q(x_q), .status_q(status_q)
    );

    task automatic check(input string tag, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "acc", acc_q, mA);
        check(tag, "x", x_q, mX);
        check(tag, "status", status_q, mP);
        check("R10", "ctrl bits", {4'h0, status_q[5:2]}, 8'h09);
    endtask

    task automatic model_zn(input logic [7:0] v);
        mP[1] = (v == 8'h00);
        mP[7] = v[7];
    endtask

    task automatic model_apply(input logic [2:0] op, input logic [7:0] d);
        logic [7:0] dd;
        logic [8:0] s;
        logic [7:0] r;
        case (op)
            3'd0, 3'd1: begin
                dd = (op == 3'd1) ? ~d : d;
                s  = {1'b0, mA} + {1'b0, dd} + {8'h00, mP[0]};
                r  = s[7:0];
                mP[0] = s[8];
                mP[6] = ((dd[7] ^ r[7]) & (r[7] ^ mA[7]));
                mA = r;
                model_zn(r);
            end
            3'd2: begin mA = mA & d; model_zn(mA); end
            3'd3: begin mA = d; model_zn(mA); end
            3'd4: begin mX = mA; model_zn(mX); end
            3'd5: begin mX = mX + 8'h01; model_zn(mX); end
            default: ;
        endcase
    endtask

    task automatic do_op(input logic [2:0] op, input logic [7:0] d,
                         input logic v, input string tag);
        @(negedge clk);
        op_valid = v;
        op_code  = op;
        operand  = d;
        @(negedge clk);
        op_valid = 1'b0;
        if (v) model_apply(op, d);
        check_all(tag);
    endtask

    task automatic model_reset();
        mA = 8'h00; mX = 8'h00; mP = 8'h24;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1");
    endtask

    task automatic t_add();
        do_op(3'd3, 8'h50, 1'b1, "R7");
        do_op(3'd0, 8'h50, 1'b1, "R4");
        do_op(3'd0, 8'h70, 1'b1, "R3");
        do_op(3'd0, 8'hEF, 1'b1, "R6");
    endtask

    task automatic t_sub();
        do_op(3'd3, 8'h05, 1'b1, "R7");
        do_op(3'd1, 8'h03, 1'b1, "R5");
        do_op(3'd1, 8'h03, 1'b1, "R5");
        do_op(3'd3, 8'h80, 1'b1, "R7");
        do_op(3'd1, 8'h01, 1'b1, "R4");
    endtask

    task automatic t_logic();
        do_op(3'd3, 8'hF0, 1'b1, "R7");
        do_op(3'd2, 8'h0F, 1'b1, "R7");
        do_op(3'd3, 8'hC3, 1'b1, "R6");
        do_op(3'd2, 8'h81, 1'b1, "R7");
    endtask

    task automatic t_xreg();
        do_op(3'd3, 8'hFF, 1'b1, "R7");
        do_op(3'd4, 8'h00, 1'b1, "R9");
        do_op(3'd5, 8'h00, 1'b1, "R8");
        do_op(3'd5, 8'h00, 1'b1, "R8");
        do_op(3'd3, 8'h7F, 1'b1, "R7");
        do_op(3'd4, 8'h00, 1'b1, "R9");
    endtask

    task automatic t_idle();
        do_op(3'd0, 8'h33, 1'b0, "R2");
        do_op(3'd3, 8'h00, 1'b0, "R2");
        do_op(3'd6, 8'h11, 1'b1, "R2");
        do_op(3'd7, 8'h00, 1'b1, "R2");
    endtask

    task automatic t_collide();
        do_op(3'd3, 8'h9A, 1'b1, "R7");
        @(negedge clk);
        rst = 1'b1;
        op_valid = 1'b1;
        op_code = 3'd0;
        operand = 8'h40;
        @(negedge clk);
        rst = 1'b0;
        op_valid = 1'b0;
        model_reset();
        check_all("R1");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_xreg();
        t_idle();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule